// File: doc/BRIEF.md
# Byte-Serial Link Controller (Master/Slave) with Register Port

The block moves one byte at a time over a four-wire synchronous serial link. It has one 2-bit address, 8-bit data CPU port with three registers: a data register, a control register and a status register. As link master it makes the serial clock from the system clock. The divide is chosen by software. As link slave it follows an external serial clock while its select input is held low. All four combinations of clock idle level and capture edge are supported. A write to the data register places the byte straight into the shift register. A read returns a separate receive buffer, which is filled only when a byte completes.

The block also watches the select input while it is master. If that input goes low, the block sets a fault flag, drops out of master mode and releases its pins. It drives one interrupt line. This line carries either the block's own request or a pass-through external interrupt, as the control register chooses. Output-enable signals tell the pad logic which link pins to drive.

The transfer sequencer has three states. `ST_IDLE` goes to `ST_MASTER` on a data write in master mode. `ST_IDLE` goes to `ST_SLAVE` on the first external clock edge while selected as slave. `ST_MASTER` goes back to `ST_IDLE` after its sixteenth clock edge or on a mode fault. `ST_SLAVE` goes back to `ST_IDLE` after its sixteenth clock edge or when deselected.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00 and `sck_out`, `sck_oe`, `mosi_oe`, `miso_oe` and `irq_out` are low.
- R2: Address 0 is the data register. In master mode (control bit 4 = 1), only a data write while idle starts a transfer. The written byte leaves on `mosi_out` most significant bit first, and 8 bits from `miso_in` are shifted in at the same time.
- R3: In master mode, control bits [1:0] set the serial clock half-period to 1, 2, 8 or 16 system clocks for codes 0, 1, 2 and 3, giving divides of 2, 4, 16 and 32.
- R4: Control bit 3 sets the serial clock idle level (0 low, 1 high). Control bit 2 = 0 captures input on the first clock edge of each bit, and 1 captures on the second edge. All four combinations move data correctly.
- R5: A read of address 0 returns the receive buffer. The buffer changes only when a byte completes, so a read during a later transfer returns the earlier byte.
- R6: Status bit 7 (address 2) sets when a byte completes. It clears only when a status read is followed by a data register read or write. A data access without a preceding status read leaves it set.
- R7: A data write during a transfer is ignored, so the byte on the wire is unchanged, and it sets status bit 6. Bit 6 clears by the same sequence as bit 7.
- R8: In master mode, a low `ss_n` sets status bit 4, clears control bits 4 and 6 and aborts any transfer. Bit 4 clears only when a status read is followed by a control write.
- R9: With control bit 5 = 1, `irq_out` is high exactly when control bit 7 is 1 and exactly one of status bits 7 and 4 is set. With control bit 5 = 0, `irq_out` follows `ext_irq`.
- R10: With control bit 6 = 0, no pin is driven. With bit 6 = 1, a master drives `sck_out` and `mosi_out`, and a slave drives `miso_out` only.
- R11: As slave (control bit 4 = 0, `ss_n` low), the block shifts on edges of `sck_in`, sampling `mosi_in` and driving its preloaded byte on `miso_out`. The byte completes on the sixteenth edge, and control bits [1:0] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the flag-clear sequences) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| sck_in | input | 1 | Serial clock from the pad in slave mode |
| sck_out | output | 1 | Serial clock to the pad in master mode |
| sck_oe | output | 1 | Drive enable for the clock pad |
| mosi_in | input | 1 | Serial data received as slave |
| mosi_out | output | 1 | Serial data sent as master |
| mosi_oe | output | 1 | Drive enable for the master-out pad |
| miso_in | input | 1 | Serial data received as master |
| miso_out | output | 1 | Serial data sent as slave |
| miso_oe | output | 1 | Drive enable for the slave-out pad |
| ss_n | input | 1 | Slave select, active low |
| ext_irq | input | 1 | External interrupt routed through when selected |
| irq_out | output | 1 | Selected interrupt request |

## Verification
Master transfers are run in all four polarity and phase modes. A bench slave model answers with a byte that differs from the one sent. This separates a bit-order or capture-edge error from a loopback that only looks correct. The four rate codes are each timed between the first two clock edges, which separates an off-by-one divide from a wrong code mapping. Slave transfers in both phases use a slow external clock with the rate bits set to their largest code. A write made while a transfer is running, a select drop while master, and overlapping completion and fault flags test the collision, fault and exactly-one interrupt rules. Reads with and without a preceding status read test the flag-clear sequences.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int BYTE_W = 8;
    localparam int EDGE_W = $clog2(2 * BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2
    } xfer_state_t;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_CTRL = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

    // control bit positions (software visible)
    localparam int C_IRQ_EN  = 7;
    localparam int C_PIN_EN  = 6;
    localparam int C_SRC_SEL = 5;
    localparam int C_MASTER  = 4;
    localparam int C_POL     = 3;
    localparam int C_PHA     = 2;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        unique case (rate_sel)
            2'd0:    half_m1 = CNT_W'(0);
            2'd1:    half_m1 = CNT_W'(1);
            2'd2:    half_m1 = CNT_W'(7);
            default: half_m1 = CNT_W'(15);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic sel_n_pin,
    output logic sck_edge,
    output logic sel_low
);
    logic [STAGES:0]   sck_sh;
    logic [STAGES-1:0] sel_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh <= '0;
            sel_sh <= '1;
        end else begin
            sck_sh <= {sck_sh[STAGES-1:0], sck_pin};
            sel_sh <= {sel_sh[STAGES-2:0], sel_n_pin};
        end
    end

    assign sck_edge = sck_sh[STAGES] ^ sck_sh[STAGES-1];
    assign sel_low  = !sel_sh[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample_en,
    input  logic         change_en,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] word_now,
    output logic [W-1:0] shift_next
);
    logic [W-1:0] sh_q;
    logic         out_q;

    assign shift_next = {sh_q[W-2:0], ser_in};
    assign word_now   = sh_q;
    assign ser_out    = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            sh_q  <= load_val;
            out_q <= load_val[W-1];
        end else begin
            if (sample_en) sh_q  <= shift_next;
            if (change_en) out_q <= sh_q[W-1];
        end
    end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int RATE_CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n,
    input  logic              ext_irq,
    output logic              irq_out
);
    localparam logic [EDGE_W-1:0] EDGE_LAST = '1;

    xfer_state_t       state_q, state_d;
    logic [BYTE_W-1:0] ctrl_q, rxbuf_q;
    logic              done_q, coll_q, fault_q, armed_q;
    logic [EDGE_W-1:0] edge_q;
    logic              tog_q;

    logic tick, sck_edge, sel_low;
    logic is_master, slave_sel, fault_hit;
    logic data_wr, data_rd, ctrl_wr, stat_rd, load_go;
    logic evt, evt_sample, finish;
    logic ser_in, ser_out, spi_req;
    logic [BYTE_W-1:0] word_now, shift_next;

    assign is_master = ctrl_q[C_MASTER];
    assign slave_sel = !is_master && sel_low;
    assign fault_hit = is_master && sel_low;
    assign data_wr   = bus_wr && (bus_addr == ADR_DATA);
    assign data_rd   = bus_rd && (bus_addr == ADR_DATA);
    assign ctrl_wr   = bus_wr && (bus_addr == ADR_CTRL);
    assign stat_rd   = bus_rd && (bus_addr == ADR_STAT);
    assign load_go   = data_wr && (state_q == ST_IDLE);

    assign evt        = ((state_q == ST_MASTER) && tick)
                      || (slave_sel && sck_edge && (state_q != ST_MASTER));
    assign evt_sample = evt && (edge_q[0] == ctrl_q[C_PHA]);
    assign finish     = evt && (edge_q == EDGE_LAST);
    assign ser_in     = is_master ? miso_in : mosi_in;

    spi_rate_gen #(.CNT_W(RATE_CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_MASTER),
        .rate_sel(ctrl_q[1:0]), .tick(tick)
    );

    spi_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_in), .sel_n_pin(ss_n),
        .sck_edge(sck_edge), .sel_low(sel_low)
    );

    spi_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_go), .load_val(bus_wdata),
        .sample_en(evt_sample), .change_en(evt && !evt_sample),
        .ser_in(ser_in), .ser_out(ser_out),
        .word_now(word_now), .shift_next(shift_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_go && is_master && !fault_hit) state_d = ST_MASTER;
                else if (evt)                           state_d = ST_SLAVE;
            end
            ST_MASTER: begin
                if (fault_hit || finish) state_d = ST_IDLE;
            end
            ST_SLAVE: begin
                if (!slave_sel || finish) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // edge counter, clock phase, registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q  <= '0;
            tog_q   <= 1'b0;
            ctrl_q  <= '0;
            rxbuf_q <= '0;
            done_q  <= 1'b0;
            coll_q  <= 1'b0;
            fault_q <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (state_d == ST_IDLE) begin
                edge_q <= '0;
                tog_q  <= 1'b0;
            end else if (evt) begin
                edge_q <= edge_q + 1'b1;
                tog_q  <= !tog_q;
            end

            if (ctrl_wr) ctrl_q <= bus_wdata;
            if (fault_hit) begin
                ctrl_q[C_MASTER] <= 1'b0;
                ctrl_q[C_PIN_EN] <= 1'b0;
            end

            if (stat_rd)                                armed_q <= 1'b1;
            else if (data_wr || data_rd || ctrl_wr)     armed_q <= 1'b0;

            if (armed_q && (data_wr || data_rd)) begin
                done_q <= 1'b0;
                coll_q <= 1'b0;
            end
            if (armed_q && ctrl_wr) fault_q <= 1'b0;

            if (finish) begin
                done_q  <= 1'b1;
                rxbuf_q <= evt_sample ? shift_next : word_now;
            end
            if (data_wr && (state_q != ST_IDLE)) coll_q  <= 1'b1;
            if (fault_hit)                       fault_q <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        unique case (bus_addr)
            ADR_DATA: bus_rdata = rxbuf_q;
            ADR_CTRL: bus_rdata = ctrl_q;
            ADR_STAT: bus_rdata = {done_q, coll_q, 1'b0, fault_q, 4'b0000};
            default:  bus_rdata = '0;
        endcase
    end

    assign sck_out  = ctrl_q[C_POL] ^ tog_q;
    assign sck_oe   = ctrl_q[C_PIN_EN] && is_master;
    assign mosi_oe  = ctrl_q[C_PIN_EN] && is_master;
    assign miso_oe  = ctrl_q[C_PIN_EN] && !is_master;
    assign mosi_out = ser_out;
    assign miso_out = ser_out;
    assign spi_req  = ctrl_q[C_IRQ_EN] && (done_q ^ fault_q);
    assign irq_out  = ctrl_q[C_SRC_SEL] ? spi_req : ext_irq;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input xfer_state_t       state_q,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic              done_q,
    input logic              coll_q,
    input logic              fault_q,
    input logic              sel_low,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              sck_out,
    input logic              sck_oe,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic              irq_out
);
    assert_pins_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && (sck_oe || mosi_oe)));

    assert_sck_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sck_out == ctrl_q[C_POL]));

    assert_fault_drops_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_MASTER] && sel_low) |=> (!ctrl_q[C_MASTER] && !ctrl_q[C_PIN_EN] && fault_q));

    assert_done_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) != ST_IDLE));

    assert_irq_exactly_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_SRC_SEL] && done_q && fault_q) |-> !irq_out);

    assert_busy_write_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADR_DATA) && (state_q != ST_IDLE)) |=> coll_q);
endmodule

bind spi_port_ctrl spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .ctrl_q(ctrl_q),
    .done_q(done_q), .coll_q(coll_q), .fault_q(fault_q), .sel_low(sel_low),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .sck_out(sck_out),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .irq_out(irq_out)
);

// File: tb/spi_port_ctrl_test.sv
module spi_port_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, ss_n = 1'b1, ext_irq = 1'b0;
    logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, irq_out;

    spi_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n),
        .ext_irq(ext_irq), .irq_out(irq_out)
    );

    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

    typedef struct { string req; logic [7:0] val; } item_t;
    item_t exp_q[$];
    item_t act_q[$];
    int n_cmp = 0, n_bad = 0;

    // monitor: pops expected and observed items and compares them
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_cmp++;
            if (a.val !== e.val) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected %02h", e.req, a.val, e.val);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        exp_q.push_back('{req, exp});
        act_q.push_back('{req, act});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench slave model answering a master transfer
    logic m_on = 1'b0, m_prev = 1'b0, m_cpha = 1'b0;
    int m_idx = 0, m_cyc = 0, m_half = 0, m_bit = 0;
    logic [7:0] m_rx = '0, m_sb = '0;

    always @(negedge clk) begin
        if (m_on && sck_out !== m_prev) begin
            m_prev = sck_out;
            if (m_idx == 1) m_half = m_cyc + 1;
            m_cyc = 0;
            if ((m_idx % 2) == int'(m_cpha)) m_rx = {m_rx[6:0], mosi_out};
            else begin
                m_bit = m_cpha ? 7 - m_idx / 2 : 6 - m_idx / 2;
                if (m_bit >= 0) miso_in = m_sb[m_bit];
            end
            m_idx++;
        end else m_cyc++;
    end

    function automatic logic [7:0] half_of(input logic [1:0] r);
        case (r)
            2'd0: return 8'd1;
            2'd1: return 8'd2;
            2'd2: return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

    task automatic model_arm(input logic pol, input logic pha, input logic [7:0] sb);
        m_on = 1'b0; m_prev = pol; m_idx = 0; m_cyc = 0; m_half = 0;
        m_rx = '0; m_sb = sb; m_cpha = pha; miso_in = sb[7]; m_on = 1'b1;
    endtask

    task automatic wait_done(output logic [7:0] v);
        int guard = 0;
        v = '0;
        while (!v[7] && guard < 1000) begin rd(A_STAT, v); guard++; end
    endtask

    task automatic master_xfer(input string tag, input logic pol, input logic pha,
                               input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] sb);
        logic [7:0] v;
        wr(A_CTRL, {4'b0101, pol, pha, rate});
        check({tag, " idle level R4"}, {7'd0, sck_out}, {7'd0, pol});
        model_arm(pol, pha, sb);
        wr(A_DATA, tx);
        wait_done(v);
        check({tag, " done flag R6"}, v, 8'h80);
        rd(A_DATA, v);
        check({tag, " received byte R4"}, v, sb);
        check({tag, " sent MSB first R2"}, m_rx, tx);
        check({tag, " half period R3"}, 8'(m_half), half_of(rate));
        m_on = 1'b0;
    endtask

    task automatic slave_xfer(input string tag, input logic pha, input logic [7:0] tx,
                              input logic [7:0] mb);
        logic [7:0] v, got;
        got = '0;
        ss_n = 1'b1; sck_in = 1'b0;
        wr(A_CTRL, {5'b01000, pha, 2'b11});
        wr(A_DATA, tx);
        ss_n = 1'b0;
        idle(4);
        for (int i = 7; i >= 0; i--) begin
            if (!pha) begin
                mosi_in = mb[i]; idle(6);
                sck_in = 1'b1; idle(6);
                got = {got[6:0], miso_out};
                sck_in = 1'b0; idle(6);
            end else begin
                sck_in = 1'b1; idle(6);
                mosi_in = mb[i]; got = {got[6:0], miso_out}; idle(6);
                sck_in = 1'b0; idle(6);
            end
        end
        idle(6);
        rd(A_STAT, v);
        check({tag, " slave done R11"}, v, 8'h80);
        rd(A_DATA, v);
        check({tag, " slave received R11"}, v, mb);
        check({tag, " slave sent R11"}, got, tx);
        ss_n = 1'b1;
        idle(4);
    endtask

    logic wd_done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!wd_done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_DATA, v); check("data reset R1", v, 8'h00);
        rd(A_CTRL, v); check("ctrl reset R1", v, 8'h00);
        rd(A_STAT, v); check("stat reset R1", v, 8'h00);
        check("pins reset R1", {3'd0, sck_out, sck_oe, mosi_oe, miso_oe, irq_out}, 8'h00);

        // R10 pin directions
        wr(A_CTRL, 8'h50); check("master pins R10", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h06);
        wr(A_CTRL, 8'h40); check("slave pins R10", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h01);
        wr(A_CTRL, 8'h10); check("pins off R10", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // R2/R3/R4 master modes and rates
        master_xfer("m00", 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
        master_xfer("m01", 1'b0, 1'b1, 2'd0, 8'h96, 8'hC3);
        master_xfer("m10", 1'b1, 1'b0, 2'd0, 8'h5A, 8'h0F);
        master_xfer("m11", 1'b1, 1'b1, 2'd0, 8'hE1, 8'h7E);
        master_xfer("rate1", 1'b0, 1'b0, 2'd1, 8'h11, 8'h88);
        master_xfer("rate2", 1'b1, 1'b1, 2'd2, 8'h24, 8'h42);
        master_xfer("rate3", 1'b0, 1'b0, 2'd3, 8'h81, 8'h18);

        // R5 / R7: write while busy, buffer holds previous byte
        wr(A_CTRL, 8'h53);
        model_arm(1'b0, 1'b0, 8'h3C);
        wr(A_DATA, 8'hA5);
        idle(20);
        wr(A_DATA, 8'hFF);
        rd(A_DATA, v); check("buffer holds old byte R5", v, 8'h18);
        wait_done(v);  check("collision flag R7", v, 8'hC0);
        rd(A_DATA, v); check("byte after collision R5", v, 8'h3C);
        check("ignored write R7", m_rx, 8'hA5);
        rd(A_STAT, v); check("flags cleared R7", v, 8'h00);
        m_on = 1'b0;

        // R11 slave, rate bits at max
        slave_xfer("s0", 1'b0, 8'hC6, 8'h35);
        slave_xfer("s1", 1'b1, 8'h4B, 8'hD2);

        // R8 / R9 / R6: fault, exactly-one interrupt, clear sequences
        wr(A_CTRL, 8'hF0);
        model_arm(1'b0, 1'b0, 8'h81);
        wr(A_DATA, 8'h42);
        idle(40);
        check("irq on done R9", {7'd0, irq_out}, 8'h01);
        ss_n = 1'b0;
        idle(6);
        rd(A_CTRL, v); check("fault clears master R8", v, 8'hA0);
        rd(A_STAT, v); check("fault flag R8", v, 8'h90);
        check("irq both flags R9", {7'd0, irq_out}, 8'h00);
        check("pins released R8", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h00);
        wr(A_CTRL, 8'hA0);
        rd(A_STAT, v); check("fault cleared R8", v, 8'h80);
        check("irq done only R9", {7'd0, irq_out}, 8'h01);
        ss_n = 1'b1;
        m_on = 1'b0;
        wr(A_CTRL, 8'h80);
        ext_irq = 1'b1; idle(1);
        check("external source high R9", {7'd0, irq_out}, 8'h01);
        ext_irq = 1'b0; idle(1);
        check("external source low R9", {7'd0, irq_out}, 8'h00);
        rd(A_DATA, v);
        rd(A_STAT, v); check("unarmed read keeps done R6", v, 8'h80);
        rd(A_DATA, v); check("buffer last byte R5", v, 8'h81);
        rd(A_STAT, v); check("armed read clears done R6", v, 8'h00);

        idle(5);
        wd_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule